// File: doc/BRIEF.md
# Single-Channel Memory Move Engine

This block is one channel of a direct memory move controller. Software loads a start source address, a start destination address, a transfer count and a set of options in one strobe. The engine then copies bytes or 16-bit words from source to destination. Each item is one read cycle on the bus followed by one write cycle. Outside logic decides when the channel is triggered and when it owns the bus. The engine raises a request whenever it has work. It starts an item only in a cycle where the grant is high.

A 3-bit mode picks the pacing. The single modes move one item per trigger. The block modes move the whole count on one trigger. The burst modes do the same as the block modes, but they step off the bus for one cycle after every four items so that other masters can get in. Each mode exists in a one-shot version, which drops the channel enable when the count is used up, and in a repeating version, which keeps the channel enabled. Each side has its own address stepping and its own byte or word width, and the engine converts between the two widths. When the count reaches its end, the count reloads and a one-cycle completion pulse is raised. In every mode except one-shot single, the addresses also return to their start values.

Top module: `dma_chan_engine`

## Requirements
- R1: While reset is high and in the first cycle after it, bus_rd, bus_wr, bus_be, blk_done and chan_en are all zero.
- R2: Each item is a read cycle (bus_rd=1, bus_addr = source address) followed in the very next cycle by a write cycle (bus_wr=1, bus_addr = destination address). bus_rd and bus_wr are never high together.
- R3: In the single modes (mode 000 and 100), one trig pulse moves exactly one item.
- R4: In the block modes (mode 001 and 101), one trig pulse moves the whole count. A new item starts every 3 cycles, so the last write comes 3N-2 cycles after the first read.
- R5: In the burst modes (mode 010, 011, 110 and 111), the pacing is the same as in R4, plus one cycle with no bus cycle after every 4th item except the last. For N=8 the span is 23 cycles.
- R6: When the count is used up, chan_en drops if mode bit 2 is 0 and stays high if mode bit 2 is 1.
- R7: Step code 00 or 01 holds the address, 10 decrements it and 11 increments it. The step is 1 for a byte side and 2 for a word side. Addresses are 20 bits wide and wrap modulo 2^20.
- R8: A byte source takes the high data lane when its address bit 0 is 1, and the low lane otherwise. A byte destination copies the byte onto both lanes, with bus_be = 10 for an odd address and 01 for an even one. A word destination uses bus_be = 11. Byte to word clears the upper byte. Word to byte keeps only the low source byte.
- R9: The count drops by one per item. After the last item, blk_done is high for exactly one cycle and the count reloads its start value.
- R10: When the count is used up in any mode other than 000, both addresses return to their start values. The next item then reads the start source address again.
- R11: A loaded count of zero makes the channel ignore triggers. No bus cycle occurs and bus_req stays low.
- R12: With grant low, no item starts, and bus_req stays high while work is pending. Raising grant lets the transfer proceed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load all configuration fields and the start values |
| cfg_enable | input | 1 | Enable value taken at load |
| cfg_mode | input | 3 | Transfer mode |
| cfg_src_step | input | 2 | Source address step code |
| cfg_dst_step | input | 2 | Destination address step code |
| cfg_src_byte | input | 1 | Source side is byte wide |
| cfg_dst_byte | input | 1 | Destination side is byte wide |
| cfg_src_addr | input | 20 | Start source address |
| cfg_dst_addr | input | 20 | Start destination address |
| cfg_size | input | 16 | Number of items per block |
| trig | input | 1 | Trigger pulse from the selected source |
| grant | input | 1 | Bus granted to this channel |
| bus_rdata | input | 16 | Read data, valid during the read cycle |
| bus_req | output | 1 | Channel wants the bus |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_addr | output | 20 | Bus byte address |
| bus_wdata | output | 16 | Write data |
| bus_be | output | 2 | Byte lane enables for writes |
| blk_done | output | 1 | One-cycle pulse when the count is used up |
| chan_en | output | 1 | Current channel enable |

## Verification
Some properties are checked on every cycle. The read and write strobes must stay exclusive, and every write must follow a read. After a completion pulse, the enable must match the repeat bit. The count must decrement or reload correctly. Stepped and rewound addresses must be correct, and no cycle may start with a zero count or without a grant. Only the bench scenarios can show the pacing spans of the block and burst modes, the lane placement of byte data in memory, and that one trigger moves exactly one item or the whole block.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_GAP  = 2'd3
  } dma_st_e;

  // mode decoding helpers
  function automatic logic mode_multi(input logic [2:0] m);
    return m[1] | m[0];
  endfunction

  function automatic logic mode_burst(input logic [2:0] m);
    return m[1];
  endfunction

  function automatic logic mode_repeat(input logic [2:0] m);
    return m[2];
  endfunction
endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic [1:0]    step_sel,
  input  logic          byte_unit,
  input  logic          adv,
  input  logic          rewind,
  output logic [AW-1:0] cur
);
  logic [AW-1:0] init_q;
  logic [AW-1:0] cur_q;
  logic [AW-1:0] delta;

  assign delta = byte_unit ? AW'(1) : AW'(2);
  assign cur   = cur_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      init_q <= '0;
      cur_q  <= '0;
    end else if (load) begin
      init_q <= load_val;
      cur_q  <= load_val;
    end else if (rewind) begin
      cur_q <= init_q;
    end else if (adv) begin
      case (step_sel)
        2'b10:   cur_q <= cur_q - delta;
        2'b11:   cur_q <= cur_q + delta;
        default: cur_q <= cur_q;
      endcase
    end
  end

  a_r7_step_inc: assert property (@(posedge clk) disable iff (rst)
    (adv && !rewind && !load && step_sel == 2'b11) |=> (cur_q == $past(cur_q) + $past(delta)));
  a_r7_step_dec: assert property (@(posedge clk) disable iff (rst)
    (adv && !rewind && !load && step_sel == 2'b10) |=> (cur_q == $past(cur_q) - $past(delta)));
  a_r7_step_hold: assert property (@(posedge clk) disable iff (rst)
    (adv && !rewind && !load && !step_sel[1]) |=> $stable(cur_q));
  a_r10_rewind: assert property (@(posedge clk) disable iff (rst)
    (rewind && !load) |=> (cur_q == $past(init_q)));
endmodule

// File: rtl/dma_size_ctr.sv
module dma_size_ctr #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          last,
  output logic          nonzero
);
  logic [CW-1:0] init_q;
  logic [CW-1:0] cnt_q;

  assign last    = (cnt_q == CW'(1));
  assign nonzero = (init_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      init_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      init_q <= load_val;
      cnt_q  <= load_val;
    end else if (dec) begin
      if (cnt_q == CW'(1)) cnt_q <= init_q;
      else                 cnt_q <= cnt_q - CW'(1);
    end
  end

  a_r9_reload: assert property (@(posedge clk) disable iff (rst)
    (dec && last && !load) |=> (cnt_q == $past(init_q)));
  a_r9_decrement: assert property (@(posedge clk) disable iff (rst)
    (dec && !last && !load) |=> (cnt_q == $past(cnt_q) - CW'(1)));
  a_r11_no_dec_zero: assert property (@(posedge clk) disable iff (rst)
    (init_q == '0) |-> !dec);
endmodule

// File: rtl/dma_lane_pack.sv
module dma_lane_pack #(
  parameter int DW = 16
) (
  input  logic [DW-1:0]   rdata,
  input  logic            src_byte,
  input  logic            src_hi,
  input  logic            dst_byte,
  input  logic            dst_hi,
  output logic [DW-1:0]   wdata,
  output logic [DW/8-1:0] be
);
  localparam int HW = DW / 2;
  localparam int BW = DW / 8;

  logic [HW-1:0] src_item;
  logic [DW-1:0] norm;

  always_comb begin
    src_item = src_hi ? rdata[DW-1:HW] : rdata[HW-1:0];
    // byte source: zero-extend the selected lane; word source: as read
    norm = src_byte ? {{HW{1'b0}}, src_item} : rdata;
    if (dst_byte) begin
      wdata = {norm[HW-1:0], norm[HW-1:0]};
      be    = dst_hi ? {1'b1, {(BW-1){1'b0}}} : {{(BW-1){1'b0}}, 1'b1};
    end else begin
      wdata = norm;
      be    = '1;
    end
  end
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int AW        = 20,
  parameter int DW        = 16,
  parameter int CW        = 16,
  parameter int BURST_LEN = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_load,
  input  logic            cfg_enable,
  input  logic [2:0]      cfg_mode,
  input  logic [1:0]      cfg_src_step,
  input  logic [1:0]      cfg_dst_step,
  input  logic            cfg_src_byte,
  input  logic            cfg_dst_byte,
  input  logic [AW-1:0]   cfg_src_addr,
  input  logic [AW-1:0]   cfg_dst_addr,
  input  logic [CW-1:0]   cfg_size,
  input  logic            trig,
  input  logic            grant,
  input  logic [DW-1:0]   bus_rdata,
  output logic            bus_req,
  output logic            bus_rd,
  output logic            bus_wr,
  output logic [AW-1:0]   bus_addr,
  output logic [DW-1:0]   bus_wdata,
  output logic [DW/8-1:0] bus_be,
  output logic            blk_done,
  output logic            chan_en
);
  localparam int BW  = DW / 8;
  localparam int BLW = (BURST_LEN > 2) ? $clog2(BURST_LEN) : 1;

  dma_st_e         state_q;
  logic            en_q, pend_q, act_q, done_q;
  logic [2:0]      mode_q;
  logic [1:0]      sstep_q, dstep_q;
  logic            sbyte_q, dbyte_q;
  logic [BLW-1:0]  beat_q;
  logic [DW-1:0]   data_q;

  logic [AW-1:0]   src_cur, dst_cur;
  logic            cnt_last, cnt_nz;
  logic            start, wr_fire, fin, rewind, gap_due;
  logic [DW-1:0]   pk_wdata;
  logic [BW-1:0]   pk_be;

  assign wr_fire = (state_q == ST_WR);
  assign fin     = wr_fire && cnt_last;
  assign rewind  = fin && (mode_q != 3'b000);
  assign start   = (state_q == ST_IDLE) && en_q && cnt_nz && grant && (act_q || pend_q);
  assign gap_due = mode_burst(mode_q) && act_q && (beat_q == BLW'(BURST_LEN - 1));

  dma_addr_step #(.AW(AW)) u_src (
    .clk(clk), .rst(rst), .load(cfg_load), .load_val(cfg_src_addr),
    .step_sel(sstep_q), .byte_unit(sbyte_q), .adv(wr_fire), .rewind(rewind),
    .cur(src_cur)
  );

  dma_addr_step #(.AW(AW)) u_dst (
    .clk(clk), .rst(rst), .load(cfg_load), .load_val(cfg_dst_addr),
    .step_sel(dstep_q), .byte_unit(dbyte_q), .adv(wr_fire), .rewind(rewind),
    .cur(dst_cur)
  );

  dma_size_ctr #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .load(cfg_load), .load_val(cfg_size),
    .dec(wr_fire), .last(cnt_last), .nonzero(cnt_nz)
  );

  dma_lane_pack #(.DW(DW)) u_pack (
    .rdata(data_q), .src_byte(sbyte_q), .src_hi(src_cur[0]),
    .dst_byte(dbyte_q), .dst_hi(dst_cur[0]),
    .wdata(pk_wdata), .be(pk_be)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      en_q    <= 1'b0;
      pend_q  <= 1'b0;
      act_q   <= 1'b0;
      done_q  <= 1'b0;
      mode_q  <= '0;
      sstep_q <= '0;
      dstep_q <= '0;
      sbyte_q <= 1'b0;
      dbyte_q <= 1'b0;
      beat_q  <= '0;
      data_q  <= '0;
    end else if (cfg_load) begin
      state_q <= ST_IDLE;
      en_q    <= cfg_enable;
      pend_q  <= 1'b0;
      act_q   <= 1'b0;
      done_q  <= 1'b0;
      mode_q  <= cfg_mode;
      sstep_q <= cfg_src_step;
      dstep_q <= cfg_dst_step;
      sbyte_q <= cfg_src_byte;
      dbyte_q <= cfg_dst_byte;
      beat_q  <= '0;
    end else begin
      done_q <= fin;
      if (trig && en_q && cnt_nz) pend_q <= 1'b1;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_RD;
            if (!act_q) begin
              act_q  <= mode_multi(mode_q);
              beat_q <= '0;
              pend_q <= 1'b0;
            end
          end
        end
        ST_RD: begin
          data_q  <= bus_rdata;
          state_q <= ST_WR;
        end
        ST_WR: begin
          beat_q <= beat_q + BLW'(1);
          if (fin) begin
            act_q   <= 1'b0;
            state_q <= ST_IDLE;
            if (!mode_repeat(mode_q)) en_q <= 1'b0;
          end else if (gap_due) begin
            state_q <= ST_GAP;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign bus_rd    = (state_q == ST_RD);
  assign bus_wr    = wr_fire;
  assign bus_addr  = (state_q == ST_RD) ? src_cur : dst_cur;
  assign bus_wdata = pk_wdata;
  assign bus_be    = wr_fire ? pk_be : '0;
  assign blk_done  = done_q;
  assign chan_en   = en_q;
  assign bus_req   = (state_q == ST_RD) || wr_fire ||
                     ((state_q == ST_IDLE) && en_q && cnt_nz && (act_q || pend_q));

  a_r2_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr));
  a_r2_wr_after_rd: assert property (@(posedge clk) disable iff (rst)
    bus_wr |-> $past(bus_rd));
  a_r6_oneshot_drop: assert property (@(posedge clk) disable iff (rst)
    (blk_done && !mode_q[2]) |-> !chan_en);
  a_r6_repeat_keep: assert property (@(posedge clk) disable iff (rst)
    (blk_done && mode_q[2]) |-> chan_en);
  a_r11_zero_quiet: assert property (@(posedge clk) disable iff (rst)
    !cnt_nz |-> (!bus_rd && !bus_wr));
  a_r12_no_grant_no_rd: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_IDLE) && !grant && !cfg_load) |=> !bus_rd);
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    blk_done |=> !blk_done);
endmodule

// File: tb/dma_chan_engine_tb.sv
`timescale 1ns/1ps
module dma_chan_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_load = 0, cfg_enable = 0, cfg_src_byte = 0, cfg_dst_byte = 0;
  logic [2:0]  cfg_mode = 0;
  logic [1:0]  cfg_src_step = 0, cfg_dst_step = 0;
  logic [19:0] cfg_src_addr = 0, cfg_dst_addr = 0;
  logic [15:0] cfg_size = 0;
  logic        trig = 0, grant = 1;
  logic [15:0] bus_rdata;
  logic        bus_req, bus_rd, bus_wr, blk_done, chan_en;
  logic [19:0] bus_addr;
  logic [15:0] bus_wdata;
  logic [1:0]  bus_be;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dma_chan_engine dut_i (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_enable(cfg_enable),
    .cfg_mode(cfg_mode), .cfg_src_step(cfg_src_step), .cfg_dst_step(cfg_dst_step),
    .cfg_src_byte(cfg_src_byte), .cfg_dst_byte(cfg_dst_byte),
    .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr), .cfg_size(cfg_size),
    .trig(trig), .grant(grant), .bus_rdata(bus_rdata),
    .bus_req(bus_req), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .blk_done(blk_done), .chan_en(chan_en)
  );

  // memory model: 256 words, word index = addr[8:1]
  function automatic logic [15:0] seed(input int i);
    logic [7:0] b;
    b = 8'(i);
    return {b ^ 8'h5A, b};
  endfunction

  function automatic logic [7:0] byte_at(input logic [19:0] a);
    logic [15:0] w;
    w = seed(int'(a[8:1]));
    return a[0] ? w[15:8] : w[7:0];
  endfunction

  logic [15:0] mem [0:255];
  assign bus_rdata = mem[bus_addr[8:1]];

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= seed(i);
    end else if (bus_wr) begin
      if (bus_be[0]) mem[bus_addr[8:1]][7:0]  <= bus_wdata[7:0];
      if (bus_be[1]) mem[bus_addr[8:1]][15:8] <= bus_wdata[15:8];
    end
  end

  // monitor, sampled on the falling edge
  logic        clr_mon = 0;
  int          cyc = 0, rd_n = 0, wr_n = 0, done_n = 0, first_rd = -1, last_wr = -1;
  logic [19:0] rd_log [0:15];
  logic [19:0] wr_log [0:15];
  logic [1:0]  be_log [0:15];

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (clr_mon) begin
      rd_n <= 0; wr_n <= 0; done_n <= 0; first_rd <= -1; last_wr <= -1;
    end else begin
      if (bus_rd) begin
        if (rd_n < 16) rd_log[rd_n] <= bus_addr;
        if (first_rd < 0) first_rd <= cyc;
        rd_n <= rd_n + 1;
      end
      if (bus_wr) begin
        if (wr_n < 16) begin
          wr_log[wr_n] <= bus_addr;
          be_log[wr_n] <= bus_be;
        end
        last_wr <= cyc;
        wr_n <= wr_n + 1;
      end
      if (blk_done) done_n <= done_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clear_mon();
    clr_mon = 1;
    @(negedge clk);
    #1 clr_mon = 0;
  endtask

  task automatic load(input logic [2:0] m, input logic [1:0] ss, input logic [1:0] ds,
                      input logic sb, input logic db, input logic [19:0] sa,
                      input logic [19:0] da, input logic [15:0] sz, input logic en);
    @(posedge clk); #1;
    cfg_mode = m; cfg_src_step = ss; cfg_dst_step = ds; cfg_src_byte = sb;
    cfg_dst_byte = db; cfg_src_addr = sa; cfg_dst_addr = da; cfg_size = sz;
    cfg_enable = en; cfg_load = 1;
    @(posedge clk); #1;
    cfg_load = 0;
    clear_mon();
  endtask

  task automatic pulse_trig();
    @(posedge clk); #1 trig = 1;
    @(posedge clk); #1 trig = 0;
  endtask

  task automatic t_reset();
    chk(bus_rd == 0 && bus_wr == 0 && bus_be == 0, "R1", "strobes", {bus_rd, bus_wr, bus_be}, 0);
    chk(chan_en == 0 && blk_done == 0, "R1", "en/done", {chan_en, blk_done}, 0);
  endtask

  task automatic t_single();
    load(3'b000, 2'b11, 2'b11, 0, 0, 20'h00000, 20'h00100, 16'd3, 1);
    pulse_trig(); cycles(8);
    chk(wr_n == 1, "R3", "one item per trig", wr_n, 1);
    chk(rd_log[0] == 20'h00000 && wr_log[0] == 20'h00100, "R2", "rd then wr addr", wr_log[0], 20'h00100);
    chk(mem[8'h80] == seed(0), "R2", "copied word", mem[8'h80], seed(0));
    pulse_trig(); cycles(8); pulse_trig(); cycles(8);
    chk(wr_n == 3 && done_n == 1, "R9", "done after count", done_n, 1);
    chk(chan_en == 0, "R6", "oneshot enable drop", chan_en, 0);
    pulse_trig(); cycles(8);
    chk(wr_n == 3, "R6", "no move after drop", wr_n, 3);
  endtask

  task automatic t_block();
    int bad = 0;
    load(3'b001, 2'b11, 2'b11, 0, 0, 20'h00000, 20'h00120, 16'd8, 1);
    pulse_trig(); cycles(40);
    chk(wr_n == 8, "R4", "whole block one trig", wr_n, 8);
    chk(last_wr - first_rd == 22, "R4", "block span", last_wr - first_rd, 22);
    for (int k = 0; k < 8; k++) if (mem[8'h90 + k] != seed(k)) bad++;
    chk(bad == 0, "R4", "block data mismatches", bad, 0);
    chk(chan_en == 0 && done_n == 1, "R6", "block enable drop", chan_en, 0);
  endtask

  task automatic t_burst();
    load(3'b010, 2'b11, 2'b11, 0, 0, 20'h00000, 20'h00140, 16'd8, 1);
    pulse_trig(); cycles(40);
    chk(wr_n == 8, "R5", "burst count", wr_n, 8);
    chk(last_wr - first_rd == 23, "R5", "burst span", last_wr - first_rd, 23);
    chk(mem[8'hA7] == seed(7), "R5", "burst last word", mem[8'hA7], seed(7));
  endtask

  task automatic t_rep_block();
    load(3'b101, 2'b11, 2'b11, 0, 0, 20'h00000, 20'h00160, 16'd4, 1);
    pulse_trig(); cycles(20);
    chk(done_n == 1 && chan_en == 1, "R6", "repeat keeps enable", chan_en, 1);
    pulse_trig(); cycles(20);
    chk(wr_n == 8, "R9", "reloaded count", wr_n, 8);
    chk(rd_log[4] == 20'h00000 && wr_log[4] == 20'h00160, "R10", "rewind block", rd_log[4], 0);
  endtask

  task automatic t_rep_single();
    load(3'b100, 2'b11, 2'b00, 0, 0, 20'h00040, 20'h00180, 16'd2, 1);
    pulse_trig(); cycles(6); pulse_trig(); cycles(6); pulse_trig(); cycles(6);
    chk(rd_log[1] == 20'h00042 && wr_log[1] == 20'h00180, "R7", "src inc dst hold", rd_log[1], 20'h00042);
    chk(rd_log[2] == 20'h00040, "R10", "rewind single repeat", rd_log[2], 20'h00040);
    chk(done_n == 1 && chan_en == 1, "R9", "one done pulse", done_n, 1);
    chk(mem[8'hC0] == seed(8'h20), "R3", "fixed dest value", mem[8'hC0], seed(8'h20));
  endtask

  task automatic t_b2w();
    int bad = 0;
    load(3'b001, 2'b11, 2'b11, 1, 0, 20'h00011, 20'h00190, 16'd3, 1);
    pulse_trig(); cycles(20);
    for (int k = 0; k < 3; k++)
      if (mem[8'hC8 + k] != {8'h00, byte_at(20'h00011 + 20'(k))}) bad++;
    chk(bad == 0, "R8", "byte to word mismatches", bad, 0);
    chk(rd_log[1] == 20'h00012 && wr_log[1] == 20'h00192, "R7", "byte step 1 word step 2", rd_log[1], 20'h00012);
  endtask

  task automatic t_w2b();
    load(3'b001, 2'b11, 2'b11, 0, 1, 20'h00020, 20'h001A0, 16'd4, 1);
    pulse_trig(); cycles(20);
    chk(mem[8'hD0] == 16'h1110 && mem[8'hD1] == 16'h1312, "R8", "word to byte", mem[8'hD0], 16'h1110);
    chk(be_log[0] == 2'b01 && be_log[1] == 2'b10, "R8", "byte lanes", {be_log[0], be_log[1]}, 4'b0110);
  endtask

  task automatic t_dec();
    load(3'b001, 2'b10, 2'b01, 0, 0, 20'h00030, 20'h001B0, 16'd3, 1);
    pulse_trig(); cycles(20);
    chk(rd_log[1] == 20'h0002E && rd_log[2] == 20'h0002C, "R7", "decrement", rd_log[2], 20'h0002C);
    chk(wr_log[2] == 20'h001B0 && mem[8'hD8] == seed(8'h16), "R7", "step 01 hold", wr_log[2], 20'h001B0);
  endtask

  task automatic t_wrap();
    load(3'b001, 2'b11, 2'b11, 0, 0, 20'hFFFFE, 20'h001C0, 16'd2, 1);
    pulse_trig(); cycles(12);
    chk(rd_log[1] == 20'h00000, "R7", "20-bit wrap", rd_log[1], 0);
    chk(mem[8'hE0] == seed(8'hFF) && mem[8'hE1] == seed(0), "R7", "wrap data", mem[8'hE1], seed(0));
  endtask

  task automatic t_zero();
    load(3'b001, 2'b11, 2'b11, 0, 0, 20'h00000, 20'h001D0, 16'd0, 1);
    pulse_trig(); cycles(10);
    chk(rd_n == 0 && wr_n == 0, "R11", "zero count no cycle", rd_n, 0);
    chk(bus_req == 0, "R11", "zero count no request", bus_req, 0);
  endtask

  task automatic t_grant();
    grant = 0;
    load(3'b001, 2'b11, 2'b11, 0, 0, 20'h00000, 20'h001D0, 16'd2, 1);
    pulse_trig(); cycles(10);
    chk(rd_n == 0, "R12", "no cycle without grant", rd_n, 0);
    chk(bus_req == 1, "R12", "request held", bus_req, 1);
    grant = 1; cycles(12);
    chk(wr_n == 2 && mem[8'hE9] == seed(1), "R12", "proceeds on grant", wr_n, 2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst = 0;
    #0;
    @(negedge clk);
    t_reset();
    t_single();
    t_block();
    t_burst();
    t_rep_block();
    t_rep_single();
    t_b2w();
    t_w2b();
    t_dec();
    t_wrap();
    t_zero();
    t_grant();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule